// File: doc/BRIEF.md
# Pong Game Flow Controller

This block sequences a complete pong match. A five-state controller moves between a welcome screen, two kinds of rally (human opponent or automatic opponent), a pause between balls and a game-over screen. Alongside it sit three counters. The first is a two-digit decimal score. The second holds the balls still left. The third is an interval timer that counts 60 Hz ticks to measure two seconds.

The controller has no video path of its own. Its outputs are the present state, a freeze flag that holds the moving objects still, a scene-enable flag, and a message selector for the text overlay. It also drives the score digits and the ball count, which the video side reads to draw the scoreboard. The hit and miss pulses come from the object-motion logic. The button and mode switch come from the player.

Top module: `pong_flow_ctrl`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first cycle after it is released, state_o is 0, the score reads 00 and balls_o is 4. In that state msg_sel_o is 1, freeze_o is 1 and scene_on_o is 0.
- R2: State codes are 0 welcome, 1 human rally, 2 automatic rally, 3 ball pause and 4 game over. msg_sel_o is 1 in state 0, 0 in states 1 and 2, 2 in state 3, and 3 in state 4. freeze_o is high in states 0, 3 and 4. scene_on_o is low only in state 0.
- R3: In state 0, a rising edge of btn moves the controller to state 1 when auto_sw is low, or to state 2 when auto_sw is high. The same edge clears the score to 00 and reloads balls_o to 4. Holding btn high gives only one transition.
- R4: In states 1 and 2, a hit pulse without a miss pulse raises the decimal score by exactly one on the next cycle. A hit pulse in states 0, 3 or 4 leaves the score unchanged.
- R5: The score is two decimal digits, each 0 to 9. The ones digit wraps from 9 to 0 and carries into the tens digit, so 09 becomes 10 and 99 becomes 00.
- R6: In states 1 and 2, a miss pulse lowers balls_o by one and restarts a 120-tick interval. The next state is 4 when the count reaches 0, and 3 otherwise. When hit and miss arrive in the same cycle, the miss wins and the score is unchanged.
- R7: In state 3, button presses are ignored until 120 ticks have followed the miss. After that, a press returns the controller to the rally kind chosen at the start of the game, whatever auto_sw now reads.
- R8: State 4 holds while fewer than 120 ticks have followed the final miss. On the cycle after the 120th tick, the controller moves to state 0 and keeps the final score on display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | 1 | Player button, level |
| auto_sw | input | 1 | Selects the automatic opponent for the next game |
| hit | input | 1 | Paddle returned the ball, one-cycle pulse |
| miss | input | 1 | Ball passed the paddle, one-cycle pulse |
| tick60 | input | 1 | 60 Hz enable pulse, one cycle wide |
| state_o | output | 3 | Current state code |
| freeze_o | output | 1 | Hold moving objects still |
| scene_on_o | output | 1 | Draw the playfield objects |
| msg_sel_o | output | 2 | Text overlay select |
| score_tens_o | output | 4 | Score tens digit |
| score_ones_o | output | 4 | Score ones digit |
| balls_o | output | BW (3) | Balls remaining |

## Verification
The state register is a port, so any wrong transition on a press, a hit or a miss shows up on state_o, the message selector and the freeze flag in the very next cycle. A score or ball-count fault shows on the digit outputs one cycle after the pulse that caused it. A timer fault stays hidden until the pause or game-over state should end, which can be up to 120 ticks later. For that reason the bench checks the 119th and 120th tick around every pause and every game over.

// File: rtl/pong_flow_ctrl.sv
module pong_flow_ctrl #(
  parameter int TICKS = 120,
  parameter int BALLS = 4,
  localparam int TW = $clog2(TICKS + 1),
  localparam int BW = $clog2(BALLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn,
  input  logic          auto_sw,
  input  logic          hit,
  input  logic          miss,
  input  logic          tick60,
  output logic [2:0]    state_o,
  output logic          freeze_o,
  output logic          scene_on_o,
  output logic [1:0]    msg_sel_o,
  output logic [3:0]    score_tens_o,
  output logic [3:0]    score_ones_o,
  output logic [BW-1:0] balls_o
);

  typedef enum logic [2:0] {
    S_NEW  = 3'd0,
    S_PLAY = 3'd1,
    S_AUTO = 3'd2,
    S_BALL = 3'd3,
    S_OVER = 3'd4
  } st_t;

  st_t           st, nxt;
  logic          btn_q, auto_q;
  logic [TW-1:0] tmr;
  logic [3:0]    ones, tens;
  logic [BW-1:0] balls;

  wire press     = btn & ~btn_q;
  wire done      = (tmr == '0);
  wire playing   = (st == S_PLAY) || (st == S_AUTO);
  wire lose      = playing & miss;
  wire score_inc = playing & hit & ~miss;
  wire start     = (st == S_NEW) & press;
  wire last      = (balls == BW'(1));

  always_comb begin
    nxt = st;
    case (st)
      S_NEW:          if (press)         nxt = auto_sw ? S_AUTO : S_PLAY;
      S_PLAY, S_AUTO: if (miss)          nxt = last ? S_OVER : S_BALL;
      S_BALL:         if (done && press) nxt = auto_q ? S_AUTO : S_PLAY;
      S_OVER:         if (done)          nxt = S_NEW;
      default:                           nxt = S_NEW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_NEW;
      btn_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      st    <= nxt;
      btn_q <= btn;
      if (start) auto_q <= auto_sw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tmr <= '0;
    else if (lose)            tmr <= TW'(TICKS);
    else if (tick60 && !done) tmr <= tmr - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= 4'd0;
      tens <= 4'd0;
    end else if (start) begin
      ones <= 4'd0;
      tens <= 4'd0;
    end else if (score_inc) begin
      if (ones == 4'd9) begin
        ones <= 4'd0;
        tens <= (tens == 4'd9) ? 4'd0 : tens + 4'd1;
      end else begin
        ones <= ones + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     balls <= BW'(BALLS);
    else if (start) balls <= BW'(BALLS);
    else if (lose)  balls <= balls - BW'(1);
  end

  assign state_o      = st;
  assign freeze_o     = (st == S_NEW) || (st == S_BALL) || (st == S_OVER);
  assign scene_on_o   = (st != S_NEW);
  assign msg_sel_o    = (st == S_NEW)  ? 2'd1 :
                        (st == S_BALL) ? 2'd2 :
                        (st == S_OVER) ? 2'd3 : 2'd0;
  assign score_tens_o = tens;
  assign score_ones_o = ones;
  assign balls_o      = balls;

endmodule

// File: rtl/pong_flow_ctrl_chk.sv
module pong_flow_ctrl_chk #(
  parameter int TICKS = 120,
  parameter int BALLS = 4,
  parameter int BW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          btn,
  input logic          hit,
  input logic          miss,
  input logic          tick60,
  input logic [2:0]    state_o,
  input logic [3:0]    score_tens_o,
  input logic [3:0]    score_ones_o,
  input logic [BW-1:0] balls_o
);

  logic btn_d;
  int   wait_cnt;

  wire press   = btn & ~btn_d;
  wire playing = (state_o == 3'd1) || (state_o == 3'd2);
  wire [31:0] sv = 32'(score_tens_o) * 32'd10 + 32'(score_ones_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_d    <= 1'b0;
      wait_cnt <= 0;
    end else begin
      btn_d <= btn;
      if (playing && miss)           wait_cnt <= TICKS;
      else if (tick60 && wait_cnt != 0) wait_cnt <= wait_cnt - 1;
    end
  end

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  assert_digits_bcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    score_ones_o <= 4'd9 && score_tens_o <= 4'd9);

  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && press) |=>
      ((state_o == 3'd1 || state_o == 3'd2) && sv == 32'd0 && balls_o == BW'(BALLS)));

  assert_hit_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && hit && !miss) |=> (sv == ($past(sv) + 32'd1) % 32'd100));

  assert_miss_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && miss && balls_o == BW'(1)) |=> (state_o == 3'd4 && balls_o == '0));

  assert_miss_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && miss && balls_o > BW'(1)) |=>
      (state_o == 3'd3 && balls_o == $past(balls_o) - BW'(1) && $stable(sv)));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && wait_cnt != 0) |=> (state_o == 3'd3));

  assert_over_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && wait_cnt != 0) |=> (state_o == 3'd4));

endmodule

bind pong_flow_ctrl pong_flow_ctrl_chk #(.TICKS(TICKS), .BALLS(BALLS), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .btn(btn), .hit(hit), .miss(miss), .tick60(tick60),
  .state_o(state_o), .score_tens_o(score_tens_o), .score_ones_o(score_ones_o),
  .balls_o(balls_o)
);

// File: tb/pong_flow_ctrl_tb.sv
module pong_flow_ctrl_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic btn = 0, auto_sw = 0, hit = 0, miss = 0, tick60 = 0;
  logic [2:0] state_o;
  logic freeze_o, scene_on_o;
  logic [1:0] msg_sel_o;
  logic [3:0] score_tens_o, score_ones_o;
  logic [2:0] balls_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  pong_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .btn(btn), .auto_sw(auto_sw), .hit(hit), .miss(miss),
    .tick60(tick60), .state_o(state_o), .freeze_o(freeze_o), .scene_on_o(scene_on_o),
    .msg_sel_o(msg_sel_o), .score_tens_o(score_tens_o), .score_ones_o(score_ones_o),
    .balls_o(balls_o)
  );

  // {btn, auto_sw, hit, miss, tick, state, tens, ones, balls}
  localparam logic [18:0] VEC [0:6] = '{
    {5'b10000, 3'd1, 4'd0, 4'd0, 3'd4},  // R3 press, auto off
    {5'b10100, 3'd1, 4'd0, 4'd1, 3'd4},  // R3 held button, R4 hit
    {5'b00100, 3'd1, 4'd0, 4'd2, 3'd4},  // R4
    {5'b00000, 3'd1, 4'd0, 4'd2, 3'd4},  // R4 idle
    {5'b00110, 3'd3, 4'd0, 4'd2, 3'd3},  // R6 miss wins over hit
    {5'b10000, 3'd3, 4'd0, 4'd2, 3'd3},  // R7 early press ignored
    {5'b00001, 3'd3, 4'd0, 4'd2, 3'd3}   // R7 first tick
  };

  task automatic step(input logic b, a, h, m, t);
    btn = b; auto_sw = a; hit = h; miss = m; tick60 = t;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int st, input int tn, input int on, input int bl);
    int em, ef, es;
    em = (st == 0) ? 1 : (st == 3) ? 2 : (st == 4) ? 3 : 0;
    ef = (st == 0 || st == 3 || st == 4) ? 1 : 0;
    es = (st == 0) ? 0 : 1;
    checks++;
    if (int'(state_o) != st || int'(score_tens_o) != tn || int'(score_ones_o) != on ||
        int'(balls_o) != bl || int'(msg_sel_o) != em || int'(freeze_o) != ef ||
        int'(scene_on_o) != es) begin
      errors++;
      $display("FAIL %s: got st=%0d score=%0d%0d balls=%0d msg=%0d frz=%0d scn=%0d, exp st=%0d score=%0d%0d balls=%0d msg=%0d frz=%0d scn=%0d",
        tag, state_o, score_tens_o, score_ones_o, balls_o, msg_sel_o, freeze_o, scene_on_o,
        st, tn, on, bl, em, ef, es);
    end
  endtask

  task automatic ticks(input int n, input logic a);
    for (int i = 0; i < n; i++) step(0, a, 0, 0, 1);
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0, 4);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    check("R1 after release", 0, 0, 0, 4);
    step(0, 0, 1, 0, 0);
    check("R4 hit in welcome ignored", 0, 0, 0, 4);

    for (int k = 0; k < 7; k++) begin
      step(VEC[k][18], VEC[k][17], VEC[k][16], VEC[k][15], VEC[k][14]);
      check($sformatf("R2/R3/R4/R6/R7 vector %0d", k), int'(VEC[k][13:11]),
            int'(VEC[k][10:7]), int'(VEC[k][6:3]), int'(VEC[k][2:0]));
    end

    ticks(118, 0);
    step(1, 0, 0, 0, 0);
    check("R7 press at 119 ticks ignored", 3, 0, 2, 3);
    step(0, 1, 0, 0, 1);
    step(1, 1, 0, 0, 0);
    check("R7 resume latched human mode", 1, 0, 2, 3);
    step(0, 1, 0, 0, 0);

    hits(8);
    check("R5 09 to 10 carry", 1, 1, 0, 3);
    hits(89);
    check("R5 count to 99", 1, 9, 9, 3);
    hits(1);
    check("R5 99 wraps to 00", 1, 0, 0, 3);
    hits(1);
    check("R4 hit after wrap", 1, 0, 1, 3);

    step(0, 1, 0, 1, 0);
    check("R6 miss to pause", 3, 0, 1, 2);
    ticks(120, 1);
    step(1, 1, 0, 0, 0);
    check("R7 resume after full interval", 1, 0, 1, 2);
    step(0, 1, 0, 1, 0);
    check("R6 second miss", 3, 0, 1, 1);
    ticks(120, 1);
    step(1, 1, 0, 0, 0);
    check("R7 resume again", 1, 0, 1, 1);
    step(0, 1, 0, 1, 0);
    check("R6 last ball to game over", 4, 0, 1, 0);

    ticks(119, 1);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check("R8 held at 119 ticks", 4, 0, 1, 0);
    step(0, 1, 1, 0, 0);
    check("R4 hit in game over ignored", 4, 0, 1, 0);
    step(0, 1, 0, 0, 1);
    check("R8 still over on 120th tick edge", 4, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    check("R8 back to welcome, score kept", 0, 0, 1, 0);
    step(0, 1, 1, 0, 0);
    check("R4 hit in welcome ignored", 0, 0, 1, 0);
    step(1, 1, 0, 0, 0);
    check("R3 auto start clears score", 2, 0, 0, 4);
    step(1, 1, 1, 0, 0);
    check("R4 hit in auto rally", 2, 0, 1, 4);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-game reset", 0, 0, 0, 4);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    check("R1 idle after reset", 0, 0, 0, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running, exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule